// File: doc/BRIEF.md
# Palette Gray-Scale Modulator

This block turns packed frame-buffer pixel codes into on/off drive bits for a passive panel. It holds a sixteen-entry table of 4-bit intensity levels, loaded as two 32-bit words. Each pixel code, 1, 2 or 4 bits wide depending on the selected depth, picks one table entry. The chosen level then sets how many frames, out of a repeating sixteen-frame period, the pixel is driven on.

Each step takes one word carrying four pixel slots and returns four drive bits one clock later. A frame tick advances the modulation phase. The on-frames of a level are spread across the period by comparing the level with a bit-reversed phase, and each lane adds its own phase offset so that neighbouring pixels do not switch together. Loading the table with inverted values inverts the image without touching the frame buffer.

Top module: `gray_palette_mod`

## Requirements
- R1: After a synchronous reset, table entry k holds level k, the frame phase is 0, and `drive_valid` and `drive` are 0.
- R2: A table write with `pal_wr_sel`=0 loads entries 0 to 7 and with `pal_wr_sel`=1 loads entries 8 to 15. Entry (8·sel + k) takes bits [4k+3:4k] of `pal_wr_data`. Pixels presented in the same cycle still see the old table.
- R3: Lane i reads its code from `pix_word[4i+3:4i]`. With `depth` = 2 (4 bits per pixel) or 3 (treated the same way), all four slot bits index the table.
- R4: With `depth` = 1 (2 bits per pixel), only slot bits [1:0] are used. Only entries 0 to 3 can be reached, and the upper slot bits have no effect on `drive`.
- R5: With `depth` = 0 (1 bit per pixel), only slot bit 0 is used. Only entries 0 and 1 can be reached.
- R6: Over any sixteen consecutive frames, a lane with level L is on in exactly L frames. Level 0 is never on, and level 15 is on in 15 frames.
- R7: Lane i is on exactly when its level is greater than the bit-reversed value of (phase + 5·i) mod 16.
- R8: Each cycle with `frame_tick` high adds 1 (mod 16) to the phase after that cycle's step. A pixel step in the same cycle uses the phase from before the increment.
- R9: `drive_valid` equals `pix_valid` delayed by one clock. `drive` is 0 whenever `drive_valid` is 0.
- R10: A table with entry k = 15 − k gives each code k the duty 15 − k out of 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pal_wr_en | input | 1 | Table write strobe |
| pal_wr_sel | input | 1 | Table half: 0 = entries 0-7, 1 = entries 8-15 |
| pal_wr_data | input | 32 | Eight 4-bit levels, entry k of the half at bits [4k+3:4k] |
| depth | input | 2 | Bits per pixel: 0 = 1, 1 = 2, 2 or 3 = 4 |
| frame_tick | input | 1 | Advances the modulation phase by one |
| pix_valid | input | 1 | Pixel word present this cycle |
| pix_word | input | 16 | Four 4-bit pixel slots, lane i at [4i+3:4i] |
| drive_valid | output | 1 | Drive bits valid |
| drive | output | 4 | On/off drive bit per lane |

## Verification
Uniform words of one level are run across sixteen ticked frames, and the on-frames of each lane are counted. This separates a correct duty from an off-by-one compare or a phase that stalls. The identity table, the inverted table and a scrambled table are each tried, which tells a correct index-to-entry path from a swapped half or a shifted nibble. At reduced depth, words whose upper slot bits are set are compared with words whose upper bits are clear. The same words are also mixed with random palette writes and ticks, which exposes the cycle in which a write or a phase step takes effect.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
    localparam int CODE_W    = 4;
    localparam int ENTRIES   = 1 << CODE_W;
    localparam int PAL_REG_W = 32;
    localparam int PER_REG   = PAL_REG_W / CODE_W;
    localparam int PAL_REGS  = ENTRIES / PER_REG;

    typedef logic [CODE_W-1:0] level_t;

    typedef enum logic [1:0] {
        DEPTH_1  = 2'd0,
        DEPTH_2  = 2'd1,
        DEPTH_4  = 2'd2,
        DEPTH_4X = 2'd3
    } depth_e;

    typedef struct packed {
        logic                 en;
        logic                 sel;
        logic [PAL_REG_W-1:0] data;
    } pal_wr_t;

    function automatic level_t code_mask(depth_e d);
        case (d)
            DEPTH_1: return level_t'(4'h1);
            DEPTH_2: return level_t'(4'h3);
            default: return level_t'(4'hF);
        endcase
    endfunction

    function automatic level_t bit_rev(level_t v);
        level_t r;
        for (int b = 0; b < CODE_W; b++) r[b] = v[CODE_W-1-b];
        return r;
    endfunction
endpackage

// File: rtl/gpm_palette.sv
module gpm_palette
    import gpm_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  pal_wr_t                       wr,
    input  depth_e                        depth,
    input  logic [LANES*CODE_W-1:0]       pix_word,
    output logic [LANES-1:0][CODE_W-1:0]  lvl,
    output logic [ENTRIES*CODE_W-1:0]     pal_img
);
    logic [PAL_REGS-1:0][PAL_REG_W-1:0] pal_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < PAL_REGS; r++)
                for (int e = 0; e < PER_REG; e++)
                    pal_q[r][e*CODE_W +: CODE_W] <= level_t'(r*PER_REG + e);
        end else if (wr.en) begin
            pal_q[wr.sel] <= wr.data;
        end
    end

    assign pal_img = pal_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        level_t idx;
        always_comb begin
            idx    = pix_word[i*CODE_W +: CODE_W] & code_mask(depth);
            lvl[i] = pal_img[idx*CODE_W +: CODE_W];
        end
    end
endmodule

// File: rtl/gpm_phase.sv
module gpm_phase
    import gpm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    output level_t phase
);
    always_ff @(posedge clk) begin
        if (rst)       phase <= '0;
        else if (tick) phase <= phase + level_t'(1);
    end
endmodule

// File: rtl/gpm_modulator.sv
module gpm_modulator
    import gpm_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int LANE_STEP = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         valid,
    input  logic [LANES-1:0][CODE_W-1:0] lvl,
    input  level_t                       phase,
    output logic                         drive_valid,
    output logic [LANES-1:0]             drive
);
    logic [LANES-1:0] on_c;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam level_t OFS = level_t'((LANE_STEP * i) % ENTRIES);
        level_t lane_ph;
        always_comb begin
            lane_ph = phase + OFS;
            on_c[i] = lvl[i] > bit_rev(lane_ph);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_valid <= 1'b0;
            drive       <= '0;
        end else begin
            drive_valid <= valid;
            drive       <= valid ? on_c : '0;
        end
    end
endmodule

// File: rtl/gray_palette_mod.sv
module gray_palette_mod
    import gpm_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int LANE_STEP = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pal_wr_en,
    input  logic                    pal_wr_sel,
    input  logic [31:0]             pal_wr_data,
    input  logic [1:0]              depth,
    input  logic                    frame_tick,
    input  logic                    pix_valid,
    input  logic [LANES*4-1:0]      pix_word,
    output logic                    drive_valid,
    output logic [LANES-1:0]        drive
);
    pal_wr_t                        wr_w;
    logic [LANES-1:0][CODE_W-1:0]   lvl_w;
    logic [ENTRIES*CODE_W-1:0]      pal_img_w;
    level_t                         phase_w;

    assign wr_w = '{en: pal_wr_en, sel: pal_wr_sel, data: pal_wr_data};

    gpm_palette #(.LANES(LANES)) u_pal (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_w),
        .depth    (depth_e'(depth)),
        .pix_word (pix_word),
        .lvl      (lvl_w),
        .pal_img  (pal_img_w)
    );

    gpm_phase u_phase (
        .clk   (clk),
        .rst   (rst),
        .tick  (frame_tick),
        .phase (phase_w)
    );

    gpm_modulator #(.LANES(LANES), .LANE_STEP(LANE_STEP)) u_mod (
        .clk         (clk),
        .rst         (rst),
        .valid       (pix_valid),
        .lvl         (lvl_w),
        .phase       (phase_w),
        .drive_valid (drive_valid),
        .drive       (drive)
    );
endmodule

// File: rtl/gpm_checker.sv
module gpm_checker
    import gpm_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int LANE_STEP = 5
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         pal_wr_en,
    input logic                         pal_wr_sel,
    input logic [31:0]                  pal_wr_data,
    input logic                         frame_tick,
    input logic                         pix_valid,
    input logic                         drive_valid,
    input logic [LANES-1:0]             drive,
    input logic [LANES-1:0][CODE_W-1:0] lvl_w,
    input logic [ENTRIES*CODE_W-1:0]    pal_img_w,
    input level_t                       phase_w
);
    // R9: valid delayed by one clock, drive cleared when idle
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> drive_valid);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> (!drive_valid && drive == '0));

    // R8: phase steps only on a tick
    a_r8_phase_step: assert property (@(posedge clk) disable iff (rst)
        frame_tick |=> phase_w == $past(phase_w) + level_t'(1));
    a_r8_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> $stable(phase_w));

    // R2: each half of the table takes the written word
    a_r2_write_low: assert property (@(posedge clk) disable iff (rst)
        (pal_wr_en && !pal_wr_sel) |=> pal_img_w[31:0] == $past(pal_wr_data));
    a_r2_write_high: assert property (@(posedge clk) disable iff (rst)
        (pal_wr_en && pal_wr_sel) |=> pal_img_w[63:32] == $past(pal_wr_data));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        level_t lane_ph;
        assign lane_ph = phase_w + level_t'((LANE_STEP * i) % ENTRIES);
        // R6: level 0 never drives
        a_r6_level_zero_off: assert property (@(posedge clk) disable iff (rst)
            (pix_valid && lvl_w[i] == '0) |=> !drive[i]);
        // R6: level 15 drives in every phase but one
        a_r6_level_full_on: assert property (@(posedge clk) disable iff (rst)
            (pix_valid && lvl_w[i] == '1 && lane_ph != '1) |=> drive[i]);
    end
endmodule

bind gray_palette_mod gpm_checker #(.LANES(LANES), .LANE_STEP(LANE_STEP)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pal_wr_en   (pal_wr_en),
    .pal_wr_sel  (pal_wr_sel),
    .pal_wr_data (pal_wr_data),
    .frame_tick  (frame_tick),
    .pix_valid   (pix_valid),
    .drive_valid (drive_valid),
    .drive       (drive),
    .lvl_w       (lvl_w),
    .pal_img_w   (pal_img_w),
    .phase_w     (phase_w)
);

// File: tb/sim_gray_palette_mod.sv
module sim_gray_palette_mod;
    localparam int LANES = 4;
    localparam int STEP  = 5;

    logic        clk = 1'b0;
    logic        rst;
    logic        pal_wr_en, pal_wr_sel;
    logic [31:0] pal_wr_data;
    logic [1:0]  depth;
    logic        frame_tick, pix_valid;
    logic [15:0] pix_word;
    logic        drive_valid;
    logic [3:0]  drive;

    always #2 clk = ~clk;

    gray_palette_mod #(.LANES(LANES), .LANE_STEP(STEP)) u0 (
        .clk(clk), .rst(rst), .pal_wr_en(pal_wr_en), .pal_wr_sel(pal_wr_sel),
        .pal_wr_data(pal_wr_data), .depth(depth), .frame_tick(frame_tick),
        .pix_valid(pix_valid), .pix_word(pix_word),
        .drive_valid(drive_valid), .drive(drive)
    );

    logic [3:0] pal_m [16];
    logic [3:0] ph_m;
    logic [3:0] got;
    int checks = 0;
    int errors = 0;

    function automatic logic [3:0] brev(logic [3:0] v);
        return {v[0], v[1], v[2], v[3]};
    endfunction

    function automatic logic [3:0] model_drive(logic [15:0] w, logic [1:0] d, logic [3:0] ph);
        logic [3:0] r, m, c, lp;
        m = (d == 2'd0) ? 4'h1 : (d == 2'd1) ? 4'h3 : 4'hF;
        for (int i = 0; i < 4; i++) begin
            c    = w[i*4 +: 4] & m;
            lp   = ph + 4'(STEP * i);
            r[i] = pal_m[c] > brev(lp);
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Inputs are set at a negedge; outputs sampled at the following negedge.
    task automatic step(input bit v, input logic [15:0] w, input logic [1:0] d, input bit tick,
                        input bit we, input bit sel, input logic [31:0] wd, input string tag);
        logic [4:0] exp;
        pix_valid = v; pix_word = w; depth = d; frame_tick = tick;
        pal_wr_en = we; pal_wr_sel = sel; pal_wr_data = wd;
        exp = {v, v ? model_drive(w, d, ph_m) : 4'h0};
        @(negedge clk);
        got = drive;
        chk({drive_valid, drive} == exp, tag, 16'({drive_valid, drive}), 16'(exp));
        if (tick) ph_m = ph_m + 4'd1;
        if (we) for (int k = 0; k < 8; k++) pal_m[sel*8 + k] = wd[k*4 +: 4];
    endtask

    task automatic load(input logic [31:0] lo, input logic [31:0] hi);
        step(0, 0, 2, 0, 1, 0, lo, "R2 load low");
        step(0, 0, 2, 0, 1, 1, hi, "R2 load high");
    endtask

    task automatic duty(input logic [3:0] code, input int want, input string tag);
        int cnt [4];
        for (int i = 0; i < 4; i++) cnt[i] = 0;
        for (int f = 0; f < 16; f++) begin
            step(1, {4{code}}, 2, 1, 0, 0, 0, tag);
            for (int i = 0; i < 4; i++) cnt[i] += int'(got[i]);
        end
        for (int i = 0; i < 4; i++) chk(cnt[i] == want, tag, 16'(cnt[i]), 16'(want));
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] a, b;
        void'($urandom(32'd1234));
        rst = 1'b1; pix_valid = 0; pix_word = 0; depth = 2; frame_tick = 0;
        pal_wr_en = 0; pal_wr_sel = 0; pal_wr_data = 0;
        for (int k = 0; k < 16; k++) pal_m[k] = 4'(k);
        ph_m = 0;
        repeat (3) @(negedge clk);
        chk({drive_valid, drive} == 5'd0, "R1 reset outputs", 16'({drive_valid, drive}), 16'h0);
        rst = 1'b0;

        // R1 R7: identity table, phase 0, lane phases 0,5,10,15 -> level 15 gives 0111
        step(1, 16'hFFFF, 2, 0, 0, 0, 0, "R1 R7 identity full");
        chk(got == 4'b0111, "R7 lane spread", 16'(got), 16'h7);
        // R1: level 3 at phase 0 -> lanes vs 0,10,5,15 -> 0001
        step(1, 16'h3333, 2, 0, 0, 0, 0, "R1 identity level3");
        chk(got == 4'b0001, "R1 R7 level3", 16'(got), 16'h1);

        // R9: idle gives nothing
        step(0, 16'hFFFF, 2, 0, 0, 0, 0, "R9 idle");

        // R6: duty per level with identity table
        duty(4'd0,  0,  "R6 level0");
        duty(4'd4,  4,  "R6 level4");
        duty(4'd9,  9,  "R6 level9");
        duty(4'd15, 15, "R6 level15");

        // R10: inverted table
        load(32'h89ABCDEF, 32'h01234567);
        duty(4'd3,  12, "R10 inverted code3");
        duty(4'd15, 0,  "R10 inverted code15");

        // R2 R3 R4 R5: scrambled table, depth masking
        load(32'h5C3A_9E71, 32'hB2D4_6F08);
        step(1, 16'hFA52, 2, 0, 0, 0, 0, "R3 depth4");
        step(1, 16'hFA52, 3, 0, 0, 0, 0, "R3 depth code3");
        step(1, 16'hEEEE, 1, 0, 0, 0, 0, "R4 depth2 high bits");
        a = got;
        step(1, 16'h2222, 1, 0, 0, 0, 0, "R4 depth2 low bits");
        chk(got == a, "R4 upper bits ignored", 16'(got), 16'(a));
        step(1, 16'hFFFF, 0, 0, 0, 0, 0, "R5 depth1 high bits");
        b = got;
        step(1, 16'h1111, 0, 0, 0, 0, 0, "R5 depth1 low bits");
        chk(got == b, "R5 upper bits ignored", 16'(got), 16'(b));

        // R2 R8: write and tick in the same cycle as a pixel
        step(1, 16'h7654, 2, 1, 1, 0, 32'h1111_1111, "R2 R8 same-cycle");
        step(1, 16'h7654, 2, 0, 0, 0, 0, "R2 R8 after");

        // random mix
        for (int n = 0; n < 400; n++) begin
            step($urandom_range(0, 3) != 0, 16'($urandom), 2'($urandom_range(0, 3)),
                 $urandom_range(0, 1) == 1, $urandom_range(0, 7) == 0,
                 1'($urandom), $urandom, "R3 R7 R8 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule